// File: doc/BRIEF.md
# Programmable Interval Timer with Interrupt

The block is a single-channel down-counter of parameterised width with a small register-mapped slave port. Software uses write and read strobes to set up a control word, a reload value and interrupt handling. A one-cycle `tick` input acts as the counting enable, and all logic runs on one clock. The counter loads its start value when software enables it. It then counts down once per tick.

When a tick arrives while the count is zero, the counter reloads. There are two reload modes. The periodic (user count) mode reloads the programmed value, so the expiry repeats every load+1 ticks. The free-running mode reloads all ones. Each expiry sets a pending interrupt unless the interrupt is masked. The pending bit drives the `irq` output and stays set until software clears it, either by reading the clear register or by disabling the timer.

Register map (word offsets on `bus_addr`): 0 control, 1 load value, 2 current count, 3 interrupt status, 4 interrupt clear.

Top module: `tmr_interval`

## Requirements
- R1: After reset the control register reads 0x2, meaning disabled, unmasked and free-running. The load value reads 0, the status reads 0 and `irq` is low.
- R2: The control register at offset 0 has bit 0 = enable, bit 1 = mode (1 free-running, 0 user count) and bit 2 = mask (1 masked). Read data appears on `bus_rdata` in the cycle after the read strobe.
- R3: A write that sets enable while the timer is disabled loads the counter from the load value. While enabled, each tick lowers the count by one. Ticks have no effect while the timer is disabled.
- R4: In user count mode, a tick at count zero reloads the load value.
- R5: In free-running mode, a tick at count zero reloads all ones.
- R6: A tick at count zero while unmasked sets the pending interrupt and drives `irq` high from the next cycle. While masked, no interrupt becomes pending.
- R7: Reading the status register at offset 3 returns the pending bit in bit 0 and leaves it unchanged.
- R8: Reading the clear register at offset 4 returns 0 and clears the pending interrupt. If an expiry occurs in the same cycle as that read, the interrupt stays pending.
- R9: A control write with enable = 0 clears the pending interrupt.
- R10: A write to the load value at offset 1 while enabled is discarded.
- R11: The current count register at offset 2 returns the live counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable pulse, one decrement per high cycle |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word offset of the register |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Registered read data |
| irq | output | 1 | Pending interrupt, level |

## Verification
The hardest case to reach from the ports is a clear read that lands in the same cycle as a new expiry. This case decides whether an interrupt is lost. The stimulus sets the load value to zero in user count mode, so every tick is an expiry. It first makes the interrupt pending, then asserts `tick` and a read of the clear register on the same clock edge. It then checks that `irq` remains high and that a later, separate clear read drops it. A vector table covers the reload values in both modes and with the interrupt masked.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned OFS_CTRL   = 0;
  localparam int unsigned OFS_LOAD   = 1;
  localparam int unsigned OFS_VALUE  = 2;
  localparam int unsigned OFS_STATUS = 3;
  localparam int unsigned OFS_CLEAR  = 4;

  typedef struct packed {
    logic mask;   // bit 2: 1 = interrupt masked
    logic free;   // bit 1: 1 = free-running reload
    logic run;    // bit 0: 1 = counting enabled
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{mask: 1'b0, free: 1'b1, run: 1'b0};
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              pending,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  load_val,
  output logic              start,
  output logic              stop,
  output logic              clr_rd,
  output logic [CNT_W-1:0]  rdata
);
  localparam int CTRL_BITS = $bits(ctrl_t);

  logic hit_ctrl, hit_load, hit_value, hit_status, hit_clear;
  ctrl_t ctrl_next;

  always_comb begin
    hit_ctrl   = (addr == ADDR_W'(OFS_CTRL));
    hit_load   = (addr == ADDR_W'(OFS_LOAD));
    hit_value  = (addr == ADDR_W'(OFS_VALUE));
    hit_status = (addr == ADDR_W'(OFS_STATUS));
    hit_clear  = (addr == ADDR_W'(OFS_CLEAR));
    ctrl_next  = ctrl_t'(wdata[CTRL_BITS-1:0]);
    start      = wr && hit_ctrl && ctrl_next.run && !ctrl.run;
    stop       = wr && hit_ctrl && !ctrl_next.run;
    clr_rd     = rd && hit_clear;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= CTRL_RESET;
      load_val <= '0;
    end else if (wr) begin
      if (hit_ctrl) ctrl <= ctrl_next;
      if (hit_load && !ctrl.run) load_val <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= '0;
      if (hit_ctrl)   rdata <= CNT_W'(ctrl);
      if (hit_load)   rdata <= load_val;
      if (hit_value)  rdata <= count;
      if (hit_status) rdata <= CNT_W'(pending);
    end
  end

  assert_reset_ctrl_R1: assert property (@(posedge clk)
    rst |=> (ctrl == CTRL_RESET && load_val == '0));
  assert_load_locked_R10: assert property (@(posedge clk) disable iff (rst)
    (wr && hit_load && ctrl.run) |=> $stable(load_val));
  assert_clear_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
    clr_rd |=> (rdata == '0));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             free,
  input  logic             tick,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic at_zero;
  logic [CNT_W-1:0] reload;

  always_comb begin
    at_zero = (count == '0);
    reload  = free ? ALL_ONES : load_val;
    expire  = run && tick && at_zero && !start;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (start) begin
      count <= load_val;
    end else if (run && tick) begin
      if (at_zero) count <= reload;
      else         count <= count - 1'b1;
    end
  end

  assert_start_loads_R3: assert property (@(posedge clk) disable iff (rst)
    start |=> (count == $past(load_val)));
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!run && !start) |=> $stable(count));
  assert_user_reload_R4: assert property (@(posedge clk) disable iff (rst)
    (expire && !free) |=> (count == $past(load_val)));
  assert_free_reload_R5: assert property (@(posedge clk) disable iff (rst)
    (expire && free) |=> (count == ALL_ONES));
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic mask,
  input  logic stop,
  input  logic clr_rd,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (rst)                  pending <= 1'b0;
    else if (stop)            pending <= 1'b0;
    else if (expire && !mask) pending <= 1'b1;
    else if (clr_rd)          pending <= 1'b0;
  end

  assert_raise_R6: assert property (@(posedge clk) disable iff (rst)
    (expire && !mask && !stop) |=> pending);
  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (!pending && mask) |=> !pending);
  assert_stop_clears_R9: assert property (@(posedge clk) disable iff (rst)
    stop |=> !pending);
  assert_clear_read_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_rd && !expire) |=> !pending);
endmodule

// File: rtl/tmr_interval.sv
module tmr_interval
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] load_val, count;
  logic             start, stop, clr_rd, expire, pending;

  tmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .count(count), .pending(pending), .ctrl(ctrl),
    .load_val(load_val), .start(start), .stop(stop), .clr_rd(clr_rd),
    .rdata(bus_rdata)
  );

  tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .run(ctrl.run), .free(ctrl.free), .tick(tick),
    .start(start), .load_val(load_val), .count(count), .expire(expire)
  );

  tmr_irq u_irq (
    .clk(clk), .rst(rst), .expire(expire), .mask(ctrl.mask), .stop(stop),
    .clr_rd(clr_rd), .pending(pending)
  );

  assign irq = pending;

  assert_irq_low_in_reset_R1: assert property (@(posedge clk)
    rst |=> !irq);
endmodule

// File: tb/test_tmr_interval.sv
module test_tmr_interval;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [2:0] addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic irq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_interval i_tmr_interval (
    .clk(clk), .rst(rst), .tick(tick), .bus_wr(wr), .bus_rd(rd),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
  );

  typedef struct packed {
    logic [W-1:0] load;
    logic         free;
    logic         mask;
    logic [7:0]   ticks;
    logic [W-1:0] exp_val;
    logic         exp_irq;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'd5, 1'b0, 1'b0, 8'd3, 32'd2,        1'b0},
    '{32'd5, 1'b0, 1'b0, 8'd6, 32'd5,        1'b1},
    '{32'd2, 1'b1, 1'b0, 8'd3, 32'hFFFFFFFF, 1'b1},
    '{32'd2, 1'b0, 1'b1, 8'd3, 32'd2,        1'b0},
    '{32'd0, 1'b0, 1'b0, 8'd1, 32'd0,        1'b1},
    '{32'd3, 1'b1, 1'b0, 8'd5, 32'hFFFFFFFE, 1'b1}
  };

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic [W-1:0] d);
    @(negedge clk); wr = 1'b1; addr = 3'(a); wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [W-1:0] d);
    @(negedge clk); rd = 1'b1; addr = 3'(a);
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
    end
    @(negedge clk); tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog got=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state, R2 field layout
    bus_read(0, d); check("R1 ctrl reset", d, 32'h2);
    bus_read(1, d); check("R1 load reset", d, 32'h0);
    bus_read(3, d); check("R1 status reset", d, 32'h0);
    check("R1 irq reset", W'(irq), 32'h0);

    // Vector table: R3 R4 R5 R6 R11
    foreach (VECS[k]) begin
      bus_write(0, {29'd0, 1'b0, VECS[k].free, 1'b0});
      bus_write(1, VECS[k].load);
      bus_write(0, {29'd0, VECS[k].mask, VECS[k].free, 1'b1});
      ticks(int'(VECS[k].ticks));
      check("R6 irq vector", W'(irq), W'(VECS[k].exp_irq));
      bus_read(3, d); check("R7 status vector", d, W'(VECS[k].exp_irq));
      bus_read(2, d); check("R11 value vector R4 R5", d, VECS[k].exp_val);
    end

    // R7 status read keeps pending; R8 clear read returns 0 and clears
    bus_write(0, 32'h0);
    bus_write(1, 32'd0);
    bus_write(0, 32'h1);
    ticks(1);
    bus_read(3, d); check("R7 status pending", d, 32'h1);
    check("R7 irq kept after status read", W'(irq), 32'h1);
    bus_read(4, d); check("R8 clear returns zero", d, 32'h0);
    check("R8 irq cleared", W'(irq), 32'h0);

    // R8 clear read in same cycle as expiry: stays pending
    ticks(1);
    check("R8 pending before race", W'(irq), 32'h1);
    @(negedge clk); rd = 1'b1; addr = 3'd4; tick = 1'b1;
    @(negedge clk); rd = 1'b0; tick = 1'b0;
    check("R8 expiry wins over clear", W'(irq), 32'h1);
    bus_read(4, d);
    check("R8 later clear", W'(irq), 32'h0);

    // R9 disable clears pending
    ticks(1);
    check("R9 pending set", W'(irq), 32'h1);
    bus_write(0, 32'h0);
    check("R9 disable clears irq", W'(irq), 32'h0);

    // R10 load write while enabled discarded
    bus_write(1, 32'd9);
    bus_write(0, 32'h1);
    bus_write(1, 32'd77);
    bus_read(1, d); check("R10 load unchanged", d, 32'd9);
    bus_read(2, d); check("R3 start loads count", d, 32'd9);

    // R3 ticks ignored while disabled
    bus_write(0, 32'h0);
    ticks(4);
    bus_read(2, d); check("R3 disabled holds count", d, 32'd9);
    check("R3 no irq while disabled", W'(irq), 32'h0);

    // R1 reset again mid-run
    bus_write(0, 32'h1);
    ticks(10);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 irq after reset", W'(irq), 32'h0);
    bus_read(0, d); check("R1 ctrl after reset", d, 32'h2);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule